// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs interrupt dispatch and return for one processor core. It keeps a latched-request vector, an in-service vector, a saved return address, a global disable flag and a supervisor flag. Each request pulse on a level sets that level's latched bit. When interrupts are globally enabled and at least one latched bit is set, the block accepts the lowest-numbered latched level N. On acceptance it saves the core's current PC, moves bit N from the latched vector to the in-service vector, sets the global disable flag, sets the supervisor flag when privilege checking is configured, and sends the core a one-cycle PC redirect to byte address N × 4.

A return request ends the lowest-numbered in-service level. It clears the global disable flag and the supervisor flag, and redirects the PC to the saved return address. If nothing is in service, a return still does everything except change the in-service vector. Separate enable and disable requests let software open or close the global gate outside of entry and return.

All state and outputs are registered. Each action appears at the ports one clock edge after the cycle in which its condition holds.

Top module: `isq_top`

## Requirements
- R1: After reset, `latched`, `pending`, `retAddr` and `pcNext` are zero, `pcLoad` and `supervisor` are 0, and `intDisable` is 1.
- R2: A 1 on `irqReq[i]` sets `latched[i]` at the next edge. A latched bit stays set until its level is accepted.
- R3: An entry happens in a cycle where `retReq`=0, `intDisable`=0 and `latched` is nonzero. It takes the lowest set index N. At the next edge `latched[N]` clears, `pending[N]` sets, `intDisable` becomes 1 and `retAddr` takes the `curPc` value of the entry cycle.
- R4: After an entry edge, `pcLoad` is 1 for one cycle with `pcNext` = N × 4.
- R5: On entry, `supervisor` becomes 1 if `privCfg`=1 and is left unchanged if `privCfg`=0.
- R6: With `retReq`=1, at the next edge the lowest set bit of `pending` clears, `intDisable` and `supervisor` become 0, and `pcLoad` is 1 with `pcNext` equal to the pre-edge `retAddr`.
- R7: A return while `pending` is zero leaves `pending` at zero and still performs every other return action of R6.
- R8: A return takes precedence over an entry in the same cycle. No entry occurs while `intDisable`=1, so `pending` holds its value in such cycles unless a return occurs.
- R9: In a cycle with neither entry nor return, `gidReq`=1 sets `intDisable`, and `gieReq`=1 alone clears it. If both are 1, `gidReq` wins.
- R10: A request on the level being accepted in the same cycle leaves that `latched` bit set while `pending` for that level also sets. Other latched bits keep their values across an entry.
- R11: `pcLoad` is 0 after every cycle that has neither an entry nor a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_LEVELS | Per-level request pulses |
| curPc | input | PC_W | Core's current PC, saved on entry |
| retReq | input | 1 | Return-from-interrupt request |
| privCfg | input | 1 | Privilege checking configured |
| gieReq | input | 1 | Global enable request |
| gidReq | input | 1 | Global disable request |
| pcNext | output | PC_W | Redirect target |
| pcLoad | output | 1 | Redirect strobe, one cycle |
| latched | output | NUM_LEVELS | Latched request vector |
| pending | output | NUM_LEVELS | In-service vector |
| retAddr | output | PC_W | Saved return address |
| intDisable | output | 1 | Global interrupt disable flag |
| supervisor | output | 1 | Supervisor-mode flag |

## Verification
A wrong latched or in-service bit shows up one edge later, either as a redirect to the wrong vector slot or as a wrong in-service vector after a return. A stale return address shows up in `pcNext` on the first return after the entry that should have saved it. A disable flag stuck in the wrong state shows up as a missing or spurious `pcLoad` pulse on the edge right after the gate condition. Because every output is compared against a reference model on every vector, each of these faults is caught on the first affected edge.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef struct packed {
    logic doEntry;
    logic doReturn;
    logic setDis;
    logic clrDis;
    logic setSup;
    logic clrSup;
  } isqStrobe_t;
endpackage

// File: rtl/isq_ctrl.sv
module isq_ctrl
  import isq_pkg::*;
#(
  parameter int NUM_LEVELS = 10,
  parameter int LVL_W = 4
) (
  input  logic [NUM_LEVELS-1:0] latched,
  input  logic [NUM_LEVELS-1:0] pending,
  input  logic                  intDisable,
  input  logic                  retReq,
  input  logic                  privCfg,
  input  logic                  gieReq,
  input  logic                  gidReq,
  output isqStrobe_t            strobe,
  output logic [NUM_LEVELS-1:0] entryMask,
  output logic [NUM_LEVELS-1:0] retMask,
  output logic [LVL_W-1:0]      entryLevel
);
  logic canEnter;

  // Isolate the lowest set bit of each vector.
  assign entryMask = latched & (~latched + NUM_LEVELS'(1));
  assign retMask   = pending & (~pending + NUM_LEVELS'(1));

  always_comb begin
    entryLevel = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (latched[i]) entryLevel = LVL_W'(i);
    end
  end

  assign canEnter = !intDisable && (latched != '0);

  always_comb begin
    strobe = '0;
    if (retReq) begin
      strobe.doReturn = 1'b1;
      strobe.clrDis   = 1'b1;
      strobe.clrSup   = 1'b1;
    end else if (canEnter) begin
      strobe.doEntry = 1'b1;
      strobe.setDis  = 1'b1;
      strobe.setSup  = privCfg;
    end else if (gidReq) begin
      strobe.setDis = 1'b1;
    end else if (gieReq) begin
      strobe.clrDis = 1'b1;
    end
  end
endmodule

// File: rtl/isq_dpath.sv
module isq_dpath
  import isq_pkg::*;
#(
  parameter int NUM_LEVELS = 10,
  parameter int PC_W = 32,
  parameter int VEC_BYTES = 4,
  parameter int LVL_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  isqStrobe_t            strobe,
  input  logic [NUM_LEVELS-1:0] entryMask,
  input  logic [NUM_LEVELS-1:0] retMask,
  input  logic [LVL_W-1:0]      entryLevel,
  input  logic [NUM_LEVELS-1:0] irqReq,
  input  logic [PC_W-1:0]       curPc,
  output logic [NUM_LEVELS-1:0] latched,
  output logic [NUM_LEVELS-1:0] pending,
  output logic [PC_W-1:0]       retAddr,
  output logic                  intDisable,
  output logic                  supervisor,
  output logic [PC_W-1:0]       pcNext,
  output logic                  pcLoad
);
  logic [NUM_LEVELS-1:0] latClr;
  logic [NUM_LEVELS-1:0] pendSet;
  logic [NUM_LEVELS-1:0] pendClr;
  logic [PC_W-1:0]       vecAddr;

  assign latClr  = strobe.doEntry  ? entryMask : '0;
  assign pendSet = strobe.doEntry  ? entryMask : '0;
  assign pendClr = strobe.doReturn ? retMask   : '0;
  assign vecAddr = PC_W'(entryLevel) * PC_W'(VEC_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latched    <= '0;
      pending    <= '0;
      retAddr    <= '0;
      intDisable <= 1'b1;
      supervisor <= 1'b0;
      pcNext     <= '0;
      pcLoad     <= 1'b0;
    end else begin
      // New requests are ORed in after the clear, so neither update is lost.
      latched <= (latched & ~latClr) | irqReq;
      pending <= (pending & ~pendClr) | pendSet;
      if (strobe.doEntry) retAddr <= curPc;
      if (strobe.setDis)      intDisable <= 1'b1;
      else if (strobe.clrDis) intDisable <= 1'b0;
      if (strobe.clrSup)      supervisor <= 1'b0;
      else if (strobe.setSup) supervisor <= 1'b1;
      pcLoad <= strobe.doEntry | strobe.doReturn;
      if (strobe.doReturn)     pcNext <= retAddr;
      else if (strobe.doEntry) pcNext <= vecAddr;
    end
  end
endmodule

// File: rtl/isq_top.sv
module isq_top
  import isq_pkg::*;
#(
  parameter int NUM_LEVELS = 10,
  parameter int PC_W = 32,
  parameter int VEC_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] irqReq,
  input  logic [PC_W-1:0]       curPc,
  input  logic                  retReq,
  input  logic                  privCfg,
  input  logic                  gieReq,
  input  logic                  gidReq,
  output logic [PC_W-1:0]       pcNext,
  output logic                  pcLoad,
  output logic [NUM_LEVELS-1:0] latched,
  output logic [NUM_LEVELS-1:0] pending,
  output logic [PC_W-1:0]       retAddr,
  output logic                  intDisable,
  output logic                  supervisor
);
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  isqStrobe_t            strobe;
  logic [NUM_LEVELS-1:0] entryMask;
  logic [NUM_LEVELS-1:0] retMask;
  logic [LVL_W-1:0]      entryLevel;

  isq_ctrl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .latched(latched), .pending(pending), .intDisable(intDisable),
    .retReq(retReq), .privCfg(privCfg), .gieReq(gieReq), .gidReq(gidReq),
    .strobe(strobe), .entryMask(entryMask), .retMask(retMask),
    .entryLevel(entryLevel)
  );

  isq_dpath #(.NUM_LEVELS(NUM_LEVELS), .PC_W(PC_W), .VEC_BYTES(VEC_BYTES),
              .LVL_W(LVL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entryMask(entryMask),
    .retMask(retMask), .entryLevel(entryLevel), .irqReq(irqReq),
    .curPc(curPc), .latched(latched), .pending(pending), .retAddr(retAddr),
    .intDisable(intDisable), .supervisor(supervisor), .pcNext(pcNext),
    .pcLoad(pcLoad)
  );
endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
  parameter int NUM_LEVELS = 10,
  parameter int PC_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-1:0] irqReq,
  input logic [PC_W-1:0]       curPc,
  input logic                  retReq,
  input logic                  privCfg,
  input logic                  gieReq,
  input logic                  gidReq,
  input logic [PC_W-1:0]       pcNext,
  input logic                  pcLoad,
  input logic [NUM_LEVELS-1:0] latched,
  input logic [NUM_LEVELS-1:0] pending,
  input logic [PC_W-1:0]       retAddr,
  input logic                  intDisable,
  input logic                  supervisor
);
  logic enterNow;
  assign enterNow = !retReq && !intDisable && (latched != '0);

  AST_ENTRY_ACTIONS: assert property (@(posedge clk) disable iff (!rstN)
    enterNow |=> intDisable && pcLoad && retAddr == $past(curPc)); // R3

  AST_ENTRY_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    enterNow |=> pcNext[1:0] == 2'b00 && $countones(pending) >= 1); // R4

  AST_SUP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enterNow && !privCfg) |=> supervisor == $past(supervisor)); // R5

  AST_SUP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (enterNow && privCfg) |=> supervisor); // R5

  AST_RETURN_ACTIONS: assert property (@(posedge clk) disable iff (!rstN)
    retReq |=> !intDisable && !supervisor && pcLoad && pcNext == $past(retAddr)); // R6

  AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && pending == '0) |=> pending == '0); // R7

  AST_BLOCKED_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (intDisable && !retReq) |=> $stable(pending)); // R8

  AST_GID_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!retReq && gidReq && (intDisable || latched == '0)) |=> intDisable); // R9

  AST_GIE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!retReq && !gidReq && gieReq && latched == '0) |=> !intDisable); // R9

  AST_REQ_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq != '0) |=> (latched & $past(irqReq)) == $past(irqReq)); // R10

  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!retReq && (intDisable || latched == '0)) |=> !pcLoad); // R11
endmodule

bind isq_top isq_checker #(.NUM_LEVELS(NUM_LEVELS), .PC_W(PC_W)) u_isq_checker (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .curPc(curPc), .retReq(retReq),
  .privCfg(privCfg), .gieReq(gieReq), .gidReq(gidReq), .pcNext(pcNext),
  .pcLoad(pcLoad), .latched(latched), .pending(pending), .retAddr(retAddr),
  .intDisable(intDisable), .supervisor(supervisor)
);

// File: tb/test_isq_top.sv
module test_isq_top;
  localparam int NL = 10;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] irqReq = '0;
  logic [PW-1:0] curPc = '0;
  logic          retReq = 1'b0;
  logic          privCfg = 1'b0;
  logic          gieReq = 1'b0;
  logic          gidReq = 1'b0;
  logic [PW-1:0] pcNext;
  logic          pcLoad;
  logic [NL-1:0] latched;
  logic [NL-1:0] pending;
  logic [PW-1:0] retAddr;
  logic          intDisable;
  logic          supervisor;

  isq_top #(.NUM_LEVELS(NL), .PC_W(PW), .VEC_BYTES(4)) i_isq_top (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .curPc(curPc), .retReq(retReq),
    .privCfg(privCfg), .gieReq(gieReq), .gidReq(gidReq), .pcNext(pcNext),
    .pcLoad(pcLoad), .latched(latched), .pending(pending), .retAddr(retAddr),
    .intDisable(intDisable), .supervisor(supervisor)
  );

  always #2 clk = ~clk;

  int nVec = 0;
  int nBad = 0;

  // Reference model state
  logic [NL-1:0] mLat, mPend;
  logic [PW-1:0] mRet, mPc;
  logic          mDis, mSup, mLoad;
  logic [PW-1:0] pcCount = 32'h0000_1000;

  task automatic cmp(input string tag, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NL-1:0] irq, input logic ret,
                      input logic gie, input logic gid, input logic priv);
    logic entry;
    int lvl;
    logic [NL-1:0] nLat, nPend;
    string tLat, tPend, tDis, tSup, tLd;
    irqReq = irq; retReq = ret; gieReq = gie; gidReq = gid; privCfg = priv;
    curPc = pcCount;
    entry = !ret && !mDis && (mLat != '0);
    lvl = -1;
    for (int i = 0; i < NL; i++) if (lvl < 0 && mLat[i]) lvl = i;
    nLat = mLat;
    if (entry) nLat[lvl] = 1'b0;
    nLat = nLat | irq;
    nPend = mPend;
    if (entry) nPend[lvl] = 1'b1;
    if (ret) begin
      for (int i = 0; i < NL; i++) begin
        if (mPend[i]) begin nPend[i] = 1'b0; break; end
      end
    end
    tLat  = (entry && irq[lvl]) ? "R10" : (entry ? "R10" : "R2");
    tPend = ret ? ((mPend == '0) ? "R7" : ((!mDis && mLat != '0) ? "R8" : "R6"))
                : (entry ? "R3" : "R8");
    tDis  = ret ? "R6" : (entry ? "R3" : "R9");
    tSup  = ret ? "R6" : "R5";
    tLd   = ret ? "R6" : (entry ? "R4" : "R11");
    if (ret) begin
      mDis = 1'b0; mSup = 1'b0; mLoad = 1'b1; mPc = mRet;
    end else if (entry) begin
      mDis = 1'b1; if (priv) mSup = 1'b1; mLoad = 1'b1;
      mPc = PW'(lvl * 4); mRet = pcCount;
    end else begin
      mLoad = 1'b0;
      if (gid) mDis = 1'b1;
      else if (gie) mDis = 1'b0;
    end
    mLat = nLat; mPend = nPend;
    @(posedge clk); #1;
    nVec++;
    cmp(tLat, "latched", PW'(latched), PW'(mLat));
    cmp(tPend, "pending", PW'(pending), PW'(mPend));
    cmp("R3", "retAddr", retAddr, mRet);
    cmp(tDis, "intDisable", PW'(intDisable), PW'(mDis));
    cmp(tSup, "supervisor", PW'(supervisor), PW'(mSup));
    cmp(tLd, "pcLoad", PW'(pcLoad), PW'(mLoad));
    if (mLoad) cmp(tLd, "pcNext", pcNext, mPc);
    irqReq = '0; retReq = 1'b0; gieReq = 1'b0; gidReq = 1'b0;
    pcCount = pcCount + 32'd4;
  endtask

  task automatic drain(input logic priv);
    for (int k = 0; k < 4 * NL && (mLat != '0 || mPend != '0); k++) begin
      step('0, (mPend != '0) && (mDis || mLat == '0), 1'b0, 1'b0, priv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    mLat = '0; mPend = '0; mRet = '0; mPc = '0;
    mDis = 1'b1; mSup = 1'b0; mLoad = 1'b0;
    // R1 reset state
    nVec++;
    cmp("R1", "latched", PW'(latched), '0);
    cmp("R1", "pending", PW'(pending), '0);
    cmp("R1", "retAddr", retAddr, '0);
    cmp("R1", "pcNext", pcNext, '0);
    cmp("R1", "pcLoad", PW'(pcLoad), '0);
    cmp("R1", "supervisor", PW'(supervisor), '0);
    cmp("R1", "intDisable", PW'(intDisable), 1);

    // R8: requests stay latched while disabled
    step(NL'(5), 1'b0, 1'b0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0, 1'b0);   // R9 enable
    drain(1'b0);

    // R3 R4 R5 R6: every level, with and without privilege
    for (int n = 0; n < NL; n++) begin
      for (int p = 0; p < 2; p++) begin
        step(NL'(1) << n, 1'b0, 1'b0, 1'b0, p[0]);
        step('0, 1'b0, 1'b0, 1'b0, p[0]);          // entry
        step('0, 1'b0, 1'b0, 1'b0, p[0]);          // R11 idle
        step('0, 1'b1, 1'b0, 1'b0, p[0]);          // return
        step('0, 1'b0, 1'b0, 1'b0, p[0]);
      end
    end

    // R3 priority sweep over request patterns
    for (int pat = 1; pat < 64; pat++) begin
      step(NL'(pat) | (NL'(pat) << 4), 1'b0, 1'b0, 1'b0, pat[1]);
      drain(pat[2]);
    end

    // R7: return with nothing in service
    step('0, 1'b1, 1'b0, 1'b0, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0, 1'b1);

    // R8: return wins over a ready entry
    step(NL'(3), 1'b0, 1'b0, 1'b0, 1'b1);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);          // enter level 0
    step('0, 1'b0, 1'b1, 1'b0, 1'b1);          // reopen gate, level 1 ready
    step('0, 1'b1, 1'b0, 1'b0, 1'b1);          // return wins
    drain(1'b1);

    // R9: both requests, then enable alone
    step('0, 1'b0, 1'b1, 1'b1, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R10: request on the level being accepted
    step(NL'(4), 1'b0, 1'b0, 1'b0, 1'b0);
    step(NL'(4) | NL'(8), 1'b0, 1'b0, 1'b0, 1'b0);
    step('0, 1'b1, 1'b0, 1'b0, 1'b0);
    drain(1'b0);
    step('0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule